// File: doc/BRIEF.md
# Quadrature Decoder with Speed Capture

This block turns the two phase signals and the once-per-turn marker pulse of a rotary encoder into a position and a speed. Each legal change of the two-bit phase state moves a 16-bit edge counter up or down. A direction flag records which way the shaft last moved. Each rising edge of the marker pulse steps a 16-bit revolution counter and clears the edge counter. The two counters together give a 32-bit position word.

In speed mode, an internal time base counts clock cycles up to a programmed period. On every match it restarts and inverts a square wave. Each time that wave goes high, the block copies the edges counted since the last copy into a speed register, pulses a valid output for one cycle, and clears the edge counter. The speed value is therefore edges per two time-base periods. Nothing counts until a start strobe arrives. Each start strobe resets every counter and the time base.

Top module: `qdec_speed_top`

## Requirements
- R1: Before the first start strobe after reset, phase and marker activity leaves `edge_count`, `rev_count` and `speed_valid` at zero. `direction` resets to 1 (up).
- R2: A start strobe clears `edge_count`, `rev_count`, `speed_val` and the time base, sets `direction` to 1, and enables counting from the following cycle.
- R3: The phase state is {phase_a, phase_b}. A change 00→10, 10→11, 11→01 or 01→00 adds 1 to `edge_count`. The reverse changes subtract 1, wrapping modulo 2^16.
- R4: A change in which both phase bits flip at once leaves `edge_count` and `direction` unchanged.
- R5: `direction` becomes 1 after an up change and 0 after a down change, and holds between changes.
- R6: A rising edge of `index_in` adds 1 to `rev_count` when `direction` is 1 and subtracts 1 when it is 0. It also clears `edge_count` in the same cycle. This also holds while speed mode is on.
- R7: `pos_word` equals `rev_count` in bits 31:16 and `edge_count` in bits 15:0.
- R8: With `speed_en` high and `period` = P > 0, the first capture is seen P+1 cycles after the start strobe's edge. Later captures are seen every 2(P+1) cycles. With P = 0 there is no capture.
- R9: A capture loads `speed_val` with every edge counted since the previous capture or clear, including an edge decoded in the capture cycle itself. It leaves `edge_count` at zero.
- R10: `speed_valid` is high for exactly one cycle per `speed_val` update.
- R11: With `speed_en` low there is no capture, and `edge_count` keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| index_in | input | 1 | Once-per-turn marker, asynchronous |
| speed_en | input | 1 | Enables the time base and speed captures |
| period | input | 16 | Time-base match value; 0 disables it |
| start | input | 1 | One-cycle strobe: reset counters and run |
| edge_count | output | 16 | Signed-wrap edge counter |
| rev_count | output | 16 | Revolution counter |
| pos_word | output | 32 | {rev_count, edge_count} |
| direction | output | 1 | 1 = up, 0 = down |
| speed_val | output | 16 | Last captured edge count |
| speed_valid | output | 1 | One-cycle pulse with each capture |

## Verification
A wrong phase-decode table or a lost edge shows at `edge_count` about three cycles after the phase pins move. That delay covers the two synchroniser stages and the decode register. A fault in the time base shows as a capture pulse that is off by one or more cycles from the P+1 and 2(P+1) marks. A capture that fails to fold in its own cycle's edge shows as a mismatch when the captured values plus the residual count are summed against the edges driven. A wrong revolution step or a missed clear shows in `pos_word` as soon as the marker pulse has passed the synchroniser.

// File: rtl/qdec_pkg.sv
// Package: shared step encoding and quadrature classification helpers.
// Assumes the phase state is packed as {A, B}.
package qdec_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;

    // Successor of a phase state when rotating in the up direction.
    function automatic logic [1:0] qd_next_up(input logic [1:0] s);
        logic [1:0] n;
        case (s)
            2'b00:   n = 2'b10;
            2'b10:   n = 2'b11;
            2'b11:   n = 2'b01;
            default: n = 2'b00;
        endcase
        return n;
    endfunction

    // Classifies a state change; a change of both bits yields no step.
    function automatic step_t qd_classify(input logic [1:0] prev, input logic [1:0] cur);
        step_t r;
        if (prev == cur)                  r = STEP_NONE;
        else if (cur == qd_next_up(prev)) r = STEP_UP;
        else if (prev == qd_next_up(cur)) r = STEP_DOWN;
        else                              r = STEP_NONE;
        return r;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous bits.
// Assumes STAGES >= 1; each stage is one flip-flop per bit, reset to zero.
module qdec_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] r;
            if (g == 0) begin : g_first
                // First stage samples the raw inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= '0;
                    else        r <= d_in;
                end
            end else begin : g_next
                // Later stages pass the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= '0;
                    else        r <= g_stage[g-1].r;
                end
            end
        end
    endgenerate

    assign d_out = g_stage[STAGES-1].r;
endmodule

// File: rtl/qdec_decode.sv
// Module: turns synchronised phase and marker levels into step and rise events.
// Assumes inputs are already synchronous; events are suppressed while not running.
module qdec_decode
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  a_s,
    input  logic  b_s,
    input  logic  idx_s,
    output step_t step,
    output logic  idx_rise
);
    logic [1:0] prev_ab;
    logic       prev_idx;

    // Remembers the last phase state and marker level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ab  <= 2'b00;
            prev_idx <= 1'b0;
        end else begin
            prev_ab  <= {a_s, b_s};
            prev_idx <= idx_s;
        end
    end

    // Emits one step per legal phase change and one pulse per marker rise.
    always_comb begin
        step     = run ? qd_classify(prev_ab, {a_s, b_s}) : STEP_NONE;
        idx_rise = run & idx_s & ~prev_idx;
    end
endmodule

// File: rtl/qdec_timebase.sv
// Module: self-restarting period counter with a toggling square wave.
// Raises capture in the cycle the wave is about to go high.
// Assumes a period of zero means the time base is held idle.
module qdec_timebase #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             speed_en,
    input  logic [PER_W-1:0] period,
    output logic             capture
);
    logic [PER_W-1:0] tb_cnt;
    logic             tb_wave;
    logic             active;
    logic             match;

    // Decides whether the time base may run and whether it has reached the period.
    always_comb begin
        active  = run & speed_en & (period != '0);
        match   = active & (tb_cnt >= period);
        capture = match & ~tb_wave & ~restart;
    end

    // Advances the counter, restarting it and inverting the wave on a match.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) begin
            tb_cnt  <= '0;
            tb_wave <= 1'b0;
        end else if (match) begin
            tb_cnt  <= '0;
            tb_wave <= ~tb_wave;
        end else begin
            tb_cnt  <= tb_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/qdec_counters.sv
// Module: edge, revolution and speed registers plus the direction flag.
// Assumes at most one step per cycle; a clear (marker or capture) wins over a step.
module qdec_counters
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  step_t            step,
    input  logic             idx_rise,
    input  logic             capture,
    output logic [CNT_W-1:0] edge_q,
    output logic [CNT_W-1:0] rev_q,
    output logic             dir_q,
    output logic [CNT_W-1:0] speed_q,
    output logic             valid_q
);
    logic [CNT_W-1:0] edge_next;
    logic             dir_eff;

    // Computes the edge count including this cycle's step, and the direction in force.
    always_comb begin
        case (step)
            STEP_UP:   edge_next = edge_q + 1'b1;
            STEP_DOWN: edge_next = edge_q - 1'b1;
            default:   edge_next = edge_q;
        endcase
        case (step)
            STEP_UP:   dir_eff = 1'b1;
            STEP_DOWN: dir_eff = 1'b0;
            default:   dir_eff = dir_q;
        endcase
    end

    // Updates all counters; start acts as a software trigger that zeroes them.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            edge_q  <= '0;
            rev_q   <= '0;
            dir_q   <= 1'b1;
            speed_q <= '0;
            valid_q <= 1'b0;
        end else if (run) begin
            dir_q   <= dir_eff;
            valid_q <= capture;
            if (capture)
                speed_q <= edge_next;
            if (idx_rise || capture)
                edge_q <= '0;
            else
                edge_q <= edge_next;
            if (idx_rise)
                rev_q <= dir_eff ? rev_q + 1'b1 : rev_q - 1'b1;
        end else begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/qdec_speed_top.sv
// Module: quadrature decoder top with position, revolution and speed outputs.
// Assumes asynchronous encoder inputs and a one-cycle start strobe.
module qdec_speed_top
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PER_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_a,
    input  logic               phase_b,
    input  logic               index_in,
    input  logic               speed_en,
    input  logic [PER_W-1:0]   period,
    input  logic               start,
    output logic [CNT_W-1:0]   edge_count,
    output logic [CNT_W-1:0]   rev_count,
    output logic [2*CNT_W-1:0] pos_word,
    output logic               direction,
    output logic [CNT_W-1:0]   speed_val,
    output logic               speed_valid
);
    localparam int POS_W = 2 * CNT_W;

    logic [2:0] raw_in;
    logic [2:0] sync_out;
    logic       run_q;
    step_t      step;
    logic       idx_rise;
    logic       capture;

    assign raw_in = {phase_a, phase_b, index_in};

    // Latches the running state on the first start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= 1'b0;
        else if (start) run_q <= 1'b1;
    end

    qdec_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw_in), .d_out(sync_out)
    );

    qdec_decode u_decode (
        .clk(clk), .rst_n(rst_n), .run(run_q),
        .a_s(sync_out[2]), .b_s(sync_out[1]), .idx_s(sync_out[0]),
        .step(step), .idx_rise(idx_rise)
    );

    qdec_timebase #(.PER_W(PER_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(start),
        .speed_en(speed_en), .period(period), .capture(capture)
    );

    qdec_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .run(run_q),
        .step(step), .idx_rise(idx_rise), .capture(capture),
        .edge_q(edge_count), .rev_q(rev_count), .dir_q(direction),
        .speed_q(speed_val), .valid_q(speed_valid)
    );

    assign pos_word = POS_W'({rev_count, edge_count});
endmodule

// File: rtl/qdec_checker.sv
// Module: temporal properties of the decoder, bound to the top.
// Assumes it observes the top's ports and its running flag.
module qdec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             speed_en,
    input logic [CNT_W-1:0] edge_count,
    input logic [CNT_W-1:0] rev_count,
    input logic             speed_valid
);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (edge_count == '0 && rev_count == '0 && !speed_valid));

    p_edge_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_count != $past(edge_count)) |->
            (edge_count == CNT_W'($past(edge_count) + 1'b1) ||
             edge_count == CNT_W'($past(edge_count) - 1'b1) ||
             edge_count == '0));

    p_rev_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_count != $past(rev_count)) |->
            (rev_count == CNT_W'($past(rev_count) + 1'b1) ||
             rev_count == CNT_W'($past(rev_count) - 1'b1) ||
             rev_count == '0));

    p_capture_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        speed_valid |-> edge_count == '0);

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        speed_valid |=> !speed_valid);

    p_no_speed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(speed_en) |-> !speed_valid);
endmodule

bind qdec_speed_top qdec_checker #(.CNT_W(CNT_W)) u_qdec_chk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .speed_en(speed_en),
    .edge_count(edge_count), .rev_count(rev_count), .speed_valid(speed_valid)
);

// File: tb/qdec_speed_top_bench.sv
// Bench: directed scenarios, one task each, checking their own results.
module qdec_speed_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_a = 1'b0, phase_b = 1'b0, index_in = 1'b0;
    logic        speed_en = 1'b0;
    logic [15:0] period = 16'd0;
    logic        start = 1'b0;
    logic [15:0] edge_count, rev_count, speed_val;
    logic [31:0] pos_word;
    logic        direction, speed_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int vcount = 0;
    int acc = 0;
    logic [1:0] ab = 2'b00;

    always #2.5 clk = ~clk;

    qdec_speed_top u_qdec_speed_top (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .index_in(index_in), .speed_en(speed_en), .period(period), .start(start),
        .edge_count(edge_count), .rev_count(rev_count), .pos_word(pos_word),
        .direction(direction), .speed_val(speed_val), .speed_valid(speed_valid)
    );

    // Watchdog and capture monitor.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        #1;
        if (speed_valid) begin
            vcount = vcount + 1;
            acc = acc + int'(speed_val);
        end
    end

    function automatic logic [1:0] nxt_up(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit up);
        if (up) ab = nxt_up(ab);
        else begin
            for (int k = 0; k < 4; k++) if (nxt_up(2'(k)) == ab) begin ab = 2'(k); break; end
        end
        {phase_a, phase_b} = ab;
        repeat (4) @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_index();
        index_in = 1'b1;
        repeat (3) @(negedge clk);
        index_in = 1'b0;
        settle();
    endtask

    task automatic wait_valid(input int maxc);
        for (int i = 0; i < maxc && !speed_valid; i++) @(negedge clk);
    endtask

    task automatic t_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 edge after reset", 32'(edge_count), 0);
        chk("R1 dir after reset", 32'(direction), 1);
        step(1); step(1); pulse_index();
        chk("R1 edge before start", 32'(edge_count), 0);
        chk("R1 rev before start", 32'(rev_count), 0);
        chk("R1 no capture", 32'(vcount), 0);
    endtask

    task automatic t_count();
        pulse_start();
        for (int i = 0; i < 8; i++) step(1);
        settle();
        chk("R3 up count", 32'(edge_count), 8);
        chk("R5 dir up", 32'(direction), 1);
        for (int i = 0; i < 3; i++) step(0);
        settle();
        chk("R3 down count", 32'(edge_count), 5);
        chk("R5 dir down", 32'(direction), 0);
    endtask

    task automatic t_illegal();
        ab = ~ab;
        {phase_a, phase_b} = ab;
        settle();
        chk("R4 illegal edge", 32'(edge_count), 5);
        chk("R4 illegal dir", 32'(direction), 0);
        step(1);
        settle();
        chk("R4 legal after illegal", 32'(edge_count), 6);
    endtask

    task automatic t_index();
        pulse_index();
        chk("R6 rev up", 32'(rev_count), 1);
        chk("R6 edge cleared", 32'(edge_count), 0);
        step(1); step(1); step(1);
        settle();
        chk("R7 pos word", pos_word, 32'h0001_0003);
        step(0); step(0);
        pulse_index();
        chk("R6 rev down", 32'(rev_count), 0);
        chk("R7 pos after down index", pos_word, 32'h0000_0000);
        step(1); step(1);
        settle();
        pulse_start();
        @(negedge clk);
        chk("R2 restart edge", 32'(edge_count), 0);
        chk("R2 restart dir", 32'(direction), 1);
    endtask

    task automatic t_speed();
        int gap;
        period = 16'd40;
        speed_en = 1'b1;
        vcount = 0;
        pulse_start();
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk("R8 no early capture", 32'(speed_valid), 0);
        @(negedge clk);
        chk("R8 first capture at P+1", 32'(speed_valid), 1);
        @(negedge clk);
        chk("R10 single cycle valid", 32'(speed_valid), 0);
        gap = 1;
        for (int i = 0; i < 200 && !speed_valid; i++) begin
            @(negedge clk);
            gap++;
        end
        chk("R8 capture spacing", 32'(gap), 82);
        chk("R9 idle speed zero", 32'(speed_val), 0);
        @(negedge clk);
        for (int i = 0; i < 10; i++) step(1);
        wait_valid(200);
        chk("R9 speed value", 32'(speed_val), 10);
        chk("R9 edge cleared", 32'(edge_count), 0);
        @(negedge clk);
        pulse_index();
        chk("R6 rev in speed mode", 32'(rev_count), 1);
    endtask

    task automatic t_straddle();
        int total;
        acc = 0;
        for (int i = 0; i < 60; i++) step(1);
        settle();
        total = acc + int'(edge_count);
        chk("R9 captured plus residual", 32'(total), 60);
    endtask

    task automatic t_period_zero();
        period = 16'd0;
        pulse_start();
        vcount = 0;
        step(1); step(1);
        repeat (200) @(negedge clk);
        chk("R8 period zero no capture", 32'(vcount), 0);
        chk("R8 period zero counts", 32'(edge_count), 2);
    endtask

    task automatic t_speed_off();
        period = 16'd10;
        speed_en = 1'b0;
        pulse_start();
        vcount = 0;
        step(1); step(1); step(1);
        repeat (100) @(negedge clk);
        chk("R11 no capture when off", 32'(vcount), 0);
        chk("R11 edges still counted", 32'(edge_count), 3);
    endtask

    initial begin
        t_idle();
        t_count();
        t_illegal();
        t_index();
        t_speed();
        t_straddle();
        t_period_zero();
        t_speed_off();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule